// File: doc/BRIEF.md
# Page swap crossover unit

This block carries out crossover between two linear programs that live side by side in one instruction memory. Every program is cut into pages, and one page length holds for the whole population. A program is therefore described by its base address and its page count. On a request the block picks one page in each parent and exchanges the instruction words of those two pages in place. Both pages have the same length, so neither program changes size and no memory has to be moved or reallocated.

Page numbers come from an internal 16-bit shift-register generator. Each generator value is reduced by the page count of the parent it serves, so the two parents may lose different page positions. The block drives a single memory port with a one-cycle read latency. It moves one word at a time through a single holding register. It reports progress with a busy level and a one-cycle completion pulse.

Top module: `page_xover`

## Requirements
- R1: While reset is applied and after it is released, `busy`, `done` and `memWe` are low until a request is accepted.
- R2: The generator resets to 16'hACE1 and advances once per accepted request to {s[14:0], s[15]^s[13]^s[12]^s[10]}. The value held before the advance selects the pages. The page in A is s[7:0] mod `pagesA` and the page in B is s[15:8] mod `pagesB`. A page count of zero counts as one.
- R3: The page in a parent starts at base + page × PAGE_LEN. Its words are visited in ascending address order.
- R4: Each word takes four cycles in this order: read A, read B, write the old B word to A's address, then write the old A word to B's address. The two writes fall on consecutive cycles.
- R5: When the block finishes, the two chosen pages have swapped contents and every other memory word is unchanged. This holds when the pages coincide.
- R6: `busy` is high for exactly 4 × PAGE_LEN cycles. It starts in the cycle after the request is accepted.
- R7: `done` is high for exactly one cycle. That cycle is the one directly after the last write. `busy` is low in that cycle.
- R8: A request is accepted only while both `busy` and `done` are low. A request raised at any other time causes no memory writes and does not advance the generator.
- R9: `memWe` is high only while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Crossover request |
| baseA | input | ADDR_W | Base address of parent A |
| pagesA | input | PAGE_CNT_W | Page count of parent A |
| baseB | input | ADDR_W | Base address of parent B |
| pagesB | input | PAGE_CNT_W | Page count of parent B |
| memAddr | output | ADDR_W | Memory address |
| memWe | output | 1 | Memory write enable |
| memWdata | output | DATA_W | Memory write data |
| memRdata | input | DATA_W | Memory read data, one cycle after the address |
| busy | output | 1 | High while a swap is in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two things can land in the same cycle: a new request and the completion of the current swap. The bench provokes this by raising `start` in the exact cycle that `done` is high. It also raises `start` once in the middle of a swap. A request that was wrongly accepted would show up in two ways. First, as an extra write that finds the scoreboard empty. Second, as page choices on the next real request that no longer match the modelled generator sequence. A separate case swaps a parent with itself, so that both writes of a word can hit the same address.

// File: rtl/pxo_pkg.sv
package pxo_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RDA,
    ST_RDB,
    ST_WRA,
    ST_WRB,
    ST_DONE
  } pxoState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic accept;    // capture page addresses, step generator
    logic selB;      // address parent B instead of A
    logic latchTmp;  // hold the word returning from A
    logic writeEn;   // memory write this cycle
    logic wrTmp;     // write data from the holding register
    logic stepWord;  // advance to the next word of the page
  } pxoStrobe_t;

  localparam int unsigned LFSR_W = 16;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;

endpackage

// File: rtl/pxo_ctrl.sv
module pxo_ctrl
  import pxo_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       lastWord,
  output pxoStrobe_t strobe,
  output logic       busy,
  output logic       done
);

  pxoState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          strobe.accept = 1'b1;
          stateNext     = ST_RDA;
        end
      end
      ST_RDA: stateNext = ST_RDB;
      ST_RDB: begin
        strobe.selB     = 1'b1;
        strobe.latchTmp = 1'b1;
        stateNext       = ST_WRA;
      end
      ST_WRA: begin
        strobe.writeEn = 1'b1;
        stateNext      = ST_WRB;
      end
      ST_WRB: begin
        strobe.selB     = 1'b1;
        strobe.writeEn  = 1'b1;
        strobe.wrTmp    = 1'b1;
        strobe.stepWord = 1'b1;
        stateNext       = lastWord ? ST_DONE : ST_RDA;
      end
      ST_DONE: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  assign busy = (state == ST_RDA) || (state == ST_RDB) ||
                (state == ST_WRA) || (state == ST_WRB);
  assign done = (state == ST_DONE);

endmodule

// File: rtl/pxo_datapath.sv
module pxo_datapath
  import pxo_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned PAGE_LEN   = 4,
  parameter int unsigned PAGE_CNT_W = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  pxoStrobe_t            strobe,
  input  logic [ADDR_W-1:0]     baseA,
  input  logic [PAGE_CNT_W-1:0] pagesA,
  input  logic [ADDR_W-1:0]     baseB,
  input  logic [PAGE_CNT_W-1:0] pagesB,
  input  logic [DATA_W-1:0]     memRdata,
  output logic [ADDR_W-1:0]     memAddr,
  output logic                  memWe,
  output logic [DATA_W-1:0]     memWdata,
  output logic                  lastWord
);

  localparam int unsigned WORD_W = (PAGE_LEN > 1) ? $clog2(PAGE_LEN) : 1;
  localparam int unsigned HALF_W = LFSR_W / 2;

  logic [LFSR_W-1:0]     lfsr;
  logic [LFSR_W-1:0]     lfsrNext;
  logic [PAGE_CNT_W-1:0] idxA, idxB;
  logic [ADDR_W-1:0]     pageAddrA, pageAddrB;
  logic [WORD_W-1:0]     wordIdx;
  logic [DATA_W-1:0]     tmp;

  function automatic logic [PAGE_CNT_W-1:0] pickPage(
    input logic [HALF_W-1:0]     r,
    input logic [PAGE_CNT_W-1:0] n
  );
    logic [HALF_W-1:0] d;
    d = (n == '0) ? HALF_W'(1) : HALF_W'(n);
    return PAGE_CNT_W'(r % d);
  endfunction

  assign lfsrNext = {lfsr[LFSR_W-2:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  assign idxA     = pickPage(lfsr[HALF_W-1:0], pagesA);
  assign idxB     = pickPage(lfsr[LFSR_W-1:HALF_W], pagesB);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lfsr      <= LFSR_SEED;
      pageAddrA <= '0;
      pageAddrB <= '0;
      wordIdx   <= '0;
      tmp       <= '0;
    end else begin
      if (strobe.accept) begin
        lfsr      <= lfsrNext;
        pageAddrA <= baseA + ADDR_W'(int'(idxA) * PAGE_LEN);
        pageAddrB <= baseB + ADDR_W'(int'(idxB) * PAGE_LEN);
        wordIdx   <= '0;
      end else if (strobe.stepWord) begin
        wordIdx   <= lastWord ? '0 : wordIdx + 1'b1;
      end
      if (strobe.latchTmp) tmp <= memRdata;
    end
  end

  assign lastWord = (int'(wordIdx) == PAGE_LEN - 1);
  assign memAddr  = (strobe.selB ? pageAddrB : pageAddrA) + ADDR_W'(wordIdx);
  assign memWe    = strobe.writeEn;
  assign memWdata = strobe.wrTmp ? tmp : memRdata;

endmodule

// File: rtl/page_xover.sv
module page_xover
  import pxo_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned PAGE_LEN   = 4,
  parameter int unsigned PAGE_CNT_W = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  start,
  input  logic [ADDR_W-1:0]     baseA,
  input  logic [PAGE_CNT_W-1:0] pagesA,
  input  logic [ADDR_W-1:0]     baseB,
  input  logic [PAGE_CNT_W-1:0] pagesB,
  output logic [ADDR_W-1:0]     memAddr,
  output logic                  memWe,
  output logic [DATA_W-1:0]     memWdata,
  input  logic [DATA_W-1:0]     memRdata,
  output logic                  busy,
  output logic                  done
);

  pxoStrobe_t strobe;
  logic       lastWord;

  pxo_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .lastWord (lastWord),
    .strobe   (strobe),
    .busy     (busy),
    .done     (done)
  );

  pxo_datapath #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .PAGE_LEN   (PAGE_LEN),
    .PAGE_CNT_W (PAGE_CNT_W)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .baseA    (baseA),
    .pagesA   (pagesA),
    .baseB    (baseB),
    .pagesB   (pagesB),
    .memRdata (memRdata),
    .memAddr  (memAddr),
    .memWe    (memWe),
    .memWdata (memWdata),
    .lastWord (lastWord)
  );

endmodule

// File: rtl/pxo_checker.sv
module pxo_checker #(
  parameter int unsigned PAGE_LEN = 4
) (
  input logic clk,
  input logic rstN,
  input logic start,
  input logic busy,
  input logic done,
  input logic memWe
);

  int unsigned busyRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     busyRun <= 0;
    else if (busy) busyRun <= busyRun + 1;
    else           busyRun <= 0;
  end

  assert_we_in_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> busy);

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  assert_done_after_busy_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  assert_busy_len_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (busyRun == 4 * PAGE_LEN));

  assert_accept_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> ($past(start) && !$past(done)));

  assert_write_pair_R4: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && !$past(memWe)) |=> memWe);

  assert_write_gap_R4: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && $past(memWe)) |=> !memWe);

endmodule

bind page_xover pxo_checker #(.PAGE_LEN(PAGE_LEN)) uChk (
  .clk   (clk),
  .rstN  (rstN),
  .start (start),
  .busy  (busy),
  .done  (done),
  .memWe (memWe)
);

// File: tb/sim_page_xover.sv
module sim_page_xover;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 8;
  localparam int DATA_W     = 16;
  localparam int PAGE_LEN   = 4;
  localparam int PAGE_CNT_W = 4;
  localparam int MEM_N      = 1 << ADDR_W;

  logic                  clk = 1'b0;
  logic                  rstN = 1'b0;
  logic                  start = 1'b0;
  logic [ADDR_W-1:0]     baseA = '0, baseB = '0;
  logic [PAGE_CNT_W-1:0] pagesA = '0, pagesB = '0;
  logic [ADDR_W-1:0]     memAddr;
  logic                  memWe;
  logic [DATA_W-1:0]     memWdata;
  logic [DATA_W-1:0]     memRdata = '0;
  logic                  busy, done;

  logic [DATA_W-1:0] mem    [MEM_N];
  logic [DATA_W-1:0] expMem [MEM_N];
  logic [15:0]       modelLfsr = 16'hACE1;

  typedef struct { int addr; int data; } wr_t;
  wr_t expQ[$];

  int  errors = 0;
  int  checks = 0;
  bit  finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  page_xover #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_LEN(PAGE_LEN), .PAGE_CNT_W(PAGE_CNT_W)
  ) u0 (
    .clk(clk), .rstN(rstN), .start(start),
    .baseA(baseA), .pagesA(pagesA), .baseB(baseB), .pagesB(pagesB),
    .memAddr(memAddr), .memWe(memWe), .memWdata(memWdata), .memRdata(memRdata),
    .busy(busy), .done(done)
  );

  // memory with one-cycle read latency
  always @(posedge clk) begin
    if (memWe) mem[memAddr] <= memWdata;
    memRdata <= mem[memAddr];
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: compares every write against the scoreboard queue
  always @(negedge clk) begin
    if (rstN && memWe) begin
      if (expQ.size() == 0) begin
        check(0, "R8", "unexpected write addr", int'(memAddr), -1);
      end else begin
        wr_t e;
        e = expQ.pop_front();
        check(int'(memAddr) == e.addr, "R3", "write address", int'(memAddr), e.addr);
        check(int'(memWdata) == e.data, "R4", "write data", int'(memWdata), e.data);
      end
    end
  end

  // driver: models the request, pushes expected writes, runs the swap
  task automatic doSwap(input logic [7:0] bA, input logic [3:0] pA,
                        input logic [7:0] bB, input logic [3:0] pB, input bit poke);
    int idxA, idxB, sA, sB, cyc, guard;
    idxA = int'(modelLfsr[7:0])  % ((pA == 0) ? 1 : int'(pA));   // R2
    idxB = int'(modelLfsr[15:8]) % ((pB == 0) ? 1 : int'(pB));
    modelLfsr = {modelLfsr[14:0], modelLfsr[15] ^ modelLfsr[13] ^ modelLfsr[12] ^ modelLfsr[10]};
    sA = (int'(bA) + idxA * PAGE_LEN) % MEM_N;
    sB = (int'(bB) + idxB * PAGE_LEN) % MEM_N;
    for (int i = 0; i < PAGE_LEN; i++) begin
      int a, b, oa, ob;
      a  = (sA + i) % MEM_N;
      b  = (sB + i) % MEM_N;
      oa = int'(expMem[a]);
      ob = int'(expMem[b]);
      expMem[a] = DATA_W'(ob);
      expQ.push_back('{a, ob});
      oa = (a == b) ? ob : oa;
      expMem[b] = DATA_W'(oa);
      expQ.push_back('{b, oa});
    end
    @(negedge clk);
    baseA = bA; pagesA = pA; baseB = bB; pagesB = pB; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0; guard = 0;
    while (!done && guard < 1000) begin
      if (busy) cyc++;
      if (poke && cyc == 3) begin
        start = 1'b1; baseA = bA + 8'd1; baseB = bB + 8'd3;
      end else begin
        start = 1'b0;
      end
      guard++;
      @(negedge clk);
    end
    check(cyc == 4 * PAGE_LEN, "R6", "busy cycles", cyc, 4 * PAGE_LEN);
    check(busy == 1'b0 && done == 1'b1, "R7", "busy low during done", int'(busy), 0);
    if (poke) start = 1'b1;   // request coinciding with done
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b0, "R7", "done pulse width", int'(done), 0);
    if (poke) begin
      @(negedge clk);
      check(busy == 1'b0, "R8", "request during done ignored", int'(busy), 0);
    end
    check(expQ.size() == 0, "R4", "writes outstanding", expQ.size(), 0);
    begin
      int bad;
      bad = 0;
      for (int i = 0; i < MEM_N; i++) if (mem[i] !== expMem[i]) bad++;
      check(bad == 0, "R5", "mismatching memory words", bad, 0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL R6 watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < MEM_N; i++) begin
      mem[i]    = DATA_W'(16'h5A00 ^ (i * 37));
      expMem[i] = DATA_W'(16'h5A00 ^ (i * 37));
    end
    repeat (3) @(negedge clk);
    check(busy == 1'b0 && done == 1'b0 && memWe == 1'b0, "R1", "outputs in reset",
          {busy, done, memWe}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(busy == 1'b0 && done == 1'b0 && memWe == 1'b0, "R1", "outputs after reset",
          {busy, done, memWe}, 0);

    doSwap(8'h00, 4'd4, 8'h40, 4'd3, 1'b0);   // R2 R3 distinct parents
    doSwap(8'h10, 4'd7, 8'h80, 4'd5, 1'b1);   // R8 requests mid-swap and with done
    doSwap(8'hC0, 4'd1, 8'hD0, 4'd1, 1'b0);   // R2 single page picks page 0
    doSwap(8'hE0, 4'd0, 8'h20, 4'd2, 1'b0);   // R2 zero count treated as one
    doSwap(8'h40, 4'd3, 8'h40, 4'd3, 1'b0);   // R5 parent against itself
    doSwap(8'h60, 4'd15, 8'h00, 4'd9, 1'b1);  // R8 again, large page counts
    doSwap(8'h04, 4'd2, 8'hA0, 4'd6, 1'b0);   // R9 memWe only under busy (monitored)

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule